// File: doc/BRIEF.md
# Rate Sample Output Register Stage

This block sits between the rate-sample producer and the serial bus interface of an angular-rate sensor. Each accepted sample is a 16-bit two's complement value. The block formats the sample and stores it as two 8-bit data registers, an upper byte and a lower byte. A status byte reports which halves hold unread data and whether a sample came in before the previous one was consumed.

The bus-interface block reads registers with a 7-bit address. The read byte is presented combinationally for whatever address is applied. A one-cycle read strobe marks the access as consumed, which clears the matching flags. Three static controls set the behaviour:
- A digital enable gates sample intake.
- A pair-hold mode keeps the two data bytes coherent while software reads them one after the other.
- An alignment select picks between the full 16-bit left-justified word and a sign-extended 10-bit right-justified word.

Top module: `rate_out_regs`

## Requirements
- R1: After a synchronous active-low reset, both data registers and the status register read 0x00.
- R2: With `right_align` at 0, an accepted sample S is stored as-is: the upper register (address 0x28) reads S[15:8] and the lower register (address 0x29) reads S[7:0].
- R3: With `right_align` at 1, the 10-bit value S[15:6] is stored right-justified, and bits 15:10 of the stored word are copies of S[15].
- R4: With `hold_pair` at 0, every accepted sample replaces the stored pair, whether or not the earlier data was read.
- R5: With `hold_pair` at 1, while either half still has unread data, an incoming sample is discarded and both data registers keep their value. The first sample accepted after both halves have been read is stored.
- R6: Status (address 0x27) bit 1 is the upper-half new-data flag and bit 0 is the lower-half new-data flag. Both are set when a sample is stored. A strobed read of 0x28 clears bit 1 and a strobed read of 0x29 clears bit 0. When a store and a clear fall in the same cycle, the store wins.
- R7: Status bit 2 is the overrun flag. It is set when a sample is accepted while either new-data flag is 1. A strobed read of 0x27 returns the flag and then clears it. When a set and a clear fall in the same cycle, the set wins.
- R8: While `dig_en` is 0, `smp_valid` is ignored: data registers and status do not change.
- R9: Reading any address other than 0x27, 0x28 or 0x29 returns 0x00, and status bits 7:3 always read 0.
- R10: Applying an address without `rd_strobe` returns the register value but clears no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | One-cycle marker of a new rate sample |
| smp_data | input | 16 | Rate sample, two's complement |
| dig_en | input | 1 | Sample intake enable |
| hold_pair | input | 1 | 1: keep the data pair until both halves are read |
| right_align | input | 1 | 0: 16-bit left-justified; 1: 10-bit right-justified, sign-extended |
| rd_strobe | input | 1 | Marks the current address as read (consumes flags) |
| rd_addr | input | 7 | Register address from the bus interface |
| rd_data | output | 8 | Byte at `rd_addr` |

## Verification
The hardest state to reach from the ports is a pair that is half consumed in pair-hold mode: the upper byte has been read, the lower byte is still pending, and a fresh sample arrives. That sample must be discarded and must set overrun without touching the upper byte. The bench reaches this state with these steps:
1. Store a sample and overflow it once.
2. Strobe a read of only the upper address.
3. Push a new sample.
4. Read the lower byte, then push again, to confirm that the freeze lifts only after the second half is read.

A separate cycle drives a sample and a status-read strobe together to pin down the set-over-clear priority of overrun.

// File: rtl/rate_out_pkg.sv
// Package: shared addresses, status bit positions and flag type for the
// rate sample output register stage.
package rate_out_pkg;
    localparam int ADDR_W = 7;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 7'h27;
    localparam logic [ADDR_W-1:0] ADDR_UPPER  = 7'h28;
    localparam logic [ADDR_W-1:0] ADDR_LOWER  = 7'h29;

    localparam int ST_LO_BIT  = 0;
    localparam int ST_HI_BIT  = 1;
    localparam int ST_OVR_BIT = 2;

    typedef struct packed {
        logic ovr;
        logic hi_new;
        logic lo_new;
    } rate_flags_t;
endpackage

// File: rtl/rate_sample_fmt.sv
// Module: rate_sample_fmt
// Converts a raw two's complement sample into the stored word. Select 0
// passes the word unchanged (left-justified). Select 1 keeps the top
// NARROW_W bits, right-justifies them and fills the upper bits with the
// sign. Assumes NARROW_W <= SMP_W. Purely combinational.
module rate_sample_fmt #(
    parameter int SMP_W    = 16,
    parameter int NARROW_W = 10
) (
    input  logic [SMP_W-1:0] raw_i,
    input  logic             narrow_sel_i,
    output logic [SMP_W-1:0] word_o
);
    logic [SMP_W-1:0] narrow_word;

    generate
        if (NARROW_W < SMP_W) begin : g_ext
            localparam int PAD_W = SMP_W - NARROW_W;
            logic [NARROW_W-1:0] top_bits;
            // take the most significant NARROW_W bits and sign-extend them
            always_comb begin
                top_bits    = raw_i[SMP_W-1 -: NARROW_W];
                narrow_word = {{PAD_W{top_bits[NARROW_W-1]}}, top_bits};
            end
        end else begin : g_pass
            // narrow width equals full width: nothing to reshape
            always_comb narrow_word = raw_i;
        end
    endgenerate

    // choose between the full word and the narrow form
    always_comb word_o = narrow_sel_i ? narrow_word : raw_i;
endmodule

// File: rtl/rate_pair_store.sv
// Module: rate_pair_store
// Holds the formatted sample word that backs the upper and lower data
// registers. Loads only when load_i is high; the freeze decision is made
// by the caller. Synchronous active-low reset clears the word.
module rate_pair_store #(
    parameter int SMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [SMP_W-1:0] word_i,
    output logic [SMP_W-1:0] pair_q
);
    // capture a new word on load, otherwise keep the stored pair
    always_ff @(posedge clk) begin
        if (!rst_n)      pair_q <= '0;
        else if (load_i) pair_q <= word_i;
    end

    // R4
    load_takes_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (pair_q == $past(word_i)));

    // R5
    idle_keeps_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(pair_q));
endmodule

// File: rtl/rate_status_track.sv
// Module: rate_status_track
// Keeps the per-half new-data flags and the overrun flag. A store sets
// both new-data flags; strobed data reads clear them one at a time. An
// accepted sample that finds data pending sets overrun; a strobed status
// read clears it. Sets take priority over clears in the same cycle.
module rate_status_track
    import rate_out_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        accept_i,
    input  logic        load_i,
    input  logic        rd_hi_i,
    input  logic        rd_lo_i,
    input  logic        rd_st_i,
    output rate_flags_t flags_q,
    output logic        pending_o
);
    // any half still unread
    always_comb pending_o = flags_q.hi_new | flags_q.lo_new;

    // update new-data flags on store and on data reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q.hi_new <= 1'b0;
            flags_q.lo_new <= 1'b0;
        end else if (load_i) begin
            flags_q.hi_new <= 1'b1;
            flags_q.lo_new <= 1'b1;
        end else begin
            if (rd_hi_i) flags_q.hi_new <= 1'b0;
            if (rd_lo_i) flags_q.lo_new <= 1'b0;
        end
    end

    // update overrun on late samples and on status reads
    always_ff @(posedge clk) begin
        if (!rst_n)                      flags_q.ovr <= 1'b0;
        else if (accept_i && pending_o)  flags_q.ovr <= 1'b1;
        else if (rd_st_i)                flags_q.ovr <= 1'b0;
    end

    // R6
    store_sets_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (flags_q.hi_new && flags_q.lo_new));

    // R6
    hi_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi_i && !load_i) |=> !flags_q.hi_new);

    // R7
    late_sample_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && pending_o) |=> flags_q.ovr);

    // R7
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_st_i && !(accept_i && pending_o)) |=> !flags_q.ovr);
endmodule

// File: rtl/rate_read_mux.sv
// Module: rate_read_mux
// Selects the byte for the applied register address: status, upper half,
// lower half, or zero for any unmapped address. Combinational.
module rate_read_mux
    import rate_out_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [2*BYTE_W-1:0] pair_i,
    input  rate_flags_t         flags_i,
    output logic [BYTE_W-1:0]   data_o
);
    logic [BYTE_W-1:0] status_byte;

    // assemble the status byte from the flag positions
    always_comb begin
        status_byte             = '0;
        status_byte[ST_LO_BIT]  = flags_i.lo_new;
        status_byte[ST_HI_BIT]  = flags_i.hi_new;
        status_byte[ST_OVR_BIT] = flags_i.ovr;
    end

    // address decode for the read byte
    always_comb begin
        unique case (addr_i)
            ADDR_STATUS: data_o = status_byte;
            ADDR_UPPER:  data_o = pair_i[2*BYTE_W-1 -: BYTE_W];
            ADDR_LOWER:  data_o = pair_i[BYTE_W-1:0];
            default:     data_o = '0;
        endcase
    end
endmodule

// File: rtl/rate_out_regs.sv
// Module: rate_out_regs (top)
// Output data stage for rate samples. Accepts samples while enabled,
// formats them, stores them as an upper/lower byte pair, and tracks
// per-half new-data and overrun flags. In pair-hold mode a stored pair
// is frozen until both halves are read. Assumes smp_valid is a one-cycle
// pulse per sample and that rd_strobe marks one read per cycle.
module rate_out_regs
    import rate_out_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int NARROW_W = 10,
    localparam int SMP_W   = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_data,
    input  logic              dig_en,
    input  logic              hold_pair,
    input  logic              right_align,
    input  logic              rd_strobe,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    logic             accept;
    logic             load;
    logic             pending;
    logic             rd_hi, rd_lo, rd_st;
    logic [SMP_W-1:0] fmt_word;
    logic [SMP_W-1:0] pair;
    rate_flags_t      flags;

    // sample intake and freeze decision
    always_comb begin
        accept = smp_valid & dig_en;
        load   = accept & ~(hold_pair & pending);
    end

    // strobed read decode per register
    always_comb begin
        rd_hi = rd_strobe & (rd_addr == ADDR_UPPER);
        rd_lo = rd_strobe & (rd_addr == ADDR_LOWER);
        rd_st = rd_strobe & (rd_addr == ADDR_STATUS);
    end

    rate_sample_fmt #(.SMP_W(SMP_W), .NARROW_W(NARROW_W)) u_fmt (
        .raw_i        (smp_data),
        .narrow_sel_i (right_align),
        .word_o       (fmt_word)
    );

    rate_pair_store #(.SMP_W(SMP_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .word_i (fmt_word),
        .pair_q (pair)
    );

    rate_status_track u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .load_i    (load),
        .rd_hi_i   (rd_hi),
        .rd_lo_i   (rd_lo),
        .rd_st_i   (rd_st),
        .flags_q   (flags),
        .pending_o (pending)
    );

    rate_read_mux #(.BYTE_W(BYTE_W)) u_mux (
        .addr_i  (rd_addr),
        .pair_i  (pair),
        .flags_i (flags),
        .data_o  (rd_data)
    );

    // R5
    frozen_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_pair && pending) |=> $stable(pair));

    // R8
    disabled_intake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dig_en |=> ($stable(pair) && $stable(flags.hi_new) && $stable(flags.lo_new)));

    // R10
    no_strobe_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_strobe && !accept) |=> $stable(flags));
endmodule

// File: tb/sim_rate_out_regs.sv
module sim_rate_out_regs;
    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] A_ST = 7'h27, A_HI = 7'h28, A_LO = 7'h29;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        dig_en = 1'b1;
    logic        hold_pair = 1'b0;
    logic        right_align = 1'b0;
    logic        rd_strobe = 1'b0;
    logic [6:0]  rd_addr = '0;
    logic [7:0]  rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rate_out_regs u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .dig_en(dig_en), .hold_pair(hold_pair), .right_align(right_align),
        .rd_strobe(rd_strobe), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // look at a register without consuming it
    task automatic peek(input logic [6:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic expect_reg(input string req, input logic [6:0] a, input logic [7:0] exp);
        logic [7:0] v;
        peek(a, v);
        check(req, v, exp);
    endtask

    // strobed read: returns the byte seen during the strobe cycle
    task automatic rd(input logic [6:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_addr = a;
        rd_strobe = 1'b1;
        #1;
        v = rd_data;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic push(input logic [15:0] s);
        @(negedge clk);
        smp_data = s;
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic drain();
        logic [7:0] v;
        rd(A_HI, v);
        rd(A_LO, v);
        rd(A_ST, v);
    endtask

    task automatic t_reset();
        expect_reg("R1 status", A_ST, 8'h00);
        expect_reg("R1 upper", A_HI, 8'h00);
        expect_reg("R1 lower", A_LO, 8'h00);
    endtask

    task automatic t_left();
        right_align = 1'b0;
        push(16'h1234);
        expect_reg("R2 upper", A_HI, 8'h12);
        expect_reg("R2 lower", A_LO, 8'h34);
        expect_reg("R6 both new", A_ST, 8'h03);
        push(16'hA5C3);
        expect_reg("R2 upper neg", A_HI, 8'hA5);
        expect_reg("R2 lower neg", A_LO, 8'hC3);
    endtask

    task automatic t_right();
        drain();
        right_align = 1'b1;
        push(16'h8040);   // S[15:6] = 10'h201 -> 0xFE01
        expect_reg("R3 upper neg", A_HI, 8'hFE);
        expect_reg("R3 lower neg", A_LO, 8'h01);
        push(16'h7FC0);   // S[15:6] = 10'h1FF -> 0x01FF
        expect_reg("R3 upper pos", A_HI, 8'h01);
        expect_reg("R3 lower pos", A_LO, 8'hFF);
        right_align = 1'b0;
        drain();
    endtask

    task automatic t_flags();
        logic [7:0] v;
        push(16'h0F0E);
        expect_reg("R6 set", A_ST, 8'h03);
        rd(A_HI, v);
        check("R6 upper byte", v, 8'h0F);
        expect_reg("R6 upper cleared", A_ST, 8'h01);
        rd(A_LO, v);
        check("R6 lower byte", v, 8'h0E);
        expect_reg("R6 lower cleared", A_ST, 8'h00);
    endtask

    task automatic t_overrun();
        logic [7:0] v;
        push(16'h1111);
        push(16'h2222);
        expect_reg("R4 replaced", A_HI, 8'h22);
        rd(A_ST, v);
        check("R7 set", v, 8'h07);
        expect_reg("R7 cleared by status read", A_ST, 8'h03);
        // sample and status read in the same cycle: set wins
        @(negedge clk);
        smp_data = 16'h3333;
        smp_valid = 1'b1;
        rd_addr = A_ST;
        rd_strobe = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        rd_strobe = 1'b0;
        expect_reg("R7 set beats clear", A_ST, 8'h07);
        expect_reg("R4 third sample", A_LO, 8'h33);
        drain();
    endtask

    task automatic t_hold();
        logic [7:0] v;
        hold_pair = 1'b1;
        push(16'h4455);
        push(16'h6677);
        expect_reg("R5 frozen upper", A_HI, 8'h44);
        expect_reg("R5 frozen lower", A_LO, 8'h55);
        expect_reg("R5 ovr on discard", A_ST, 8'h07);
        rd(A_HI, v);
        check("R5 read upper", v, 8'h44);
        push(16'h8899);
        expect_reg("R5 half read still frozen", A_LO, 8'h55);
        expect_reg("R5 status half read", A_ST, 8'h05);
        rd(A_LO, v);
        check("R5 read lower", v, 8'h55);
        push(16'hAABB);
        expect_reg("R5 unfrozen upper", A_HI, 8'hAA);
        expect_reg("R5 unfrozen lower", A_LO, 8'hBB);
        expect_reg("R5 status after load", A_ST, 8'h07);
        hold_pair = 1'b0;
        drain();
    endtask

    task automatic t_enable();
        dig_en = 1'b0;
        push(16'hDEAD);
        expect_reg("R8 upper kept", A_HI, 8'hAA);
        expect_reg("R8 lower kept", A_LO, 8'hBB);
        expect_reg("R8 status kept", A_ST, 8'h00);
        dig_en = 1'b1;
    endtask

    task automatic t_addr();
        push(16'hC0DE);
        expect_reg("R9 unmapped 2A", 7'h2A, 8'h00);
        expect_reg("R9 unmapped 00", 7'h00, 8'h00);
        expect_reg("R9 unmapped 26", 7'h26, 8'h00);
        // hold the address for a few edges without a strobe
        rd_addr = A_HI;
        repeat (3) @(negedge clk);
        rd_addr = A_LO;
        repeat (3) @(negedge clk);
        expect_reg("R10 no clear", A_ST, 8'h03);
        push(16'hBEEF);
        rd_addr = A_ST;
        repeat (2) @(negedge clk);
        expect_reg("R10 ovr kept R9 upper bits", A_ST, 8'h07);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_left();
        t_right();
        t_flags();
        t_overrun();
        t_hold();
        t_enable();
        t_addr();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule